// File: doc/BRIEF.md
# Fixed-Message Partition Controller

This controller sequences a 128-row sample store that is divided into a fixed number of equal-sized message regions. A 3-bit configuration code is captured once after reset. That code selects between one and eight regions. Each region has a row count taken from a fixed allocation table, and the starting row of each region is the running sum of the counts of the regions before it. The table is uneven for some configurations. With three, six or seven messages the leftover rows go to message 1. With five messages, message 5 is the short one.

Each region has its own active-low message input. A shared record/play select chooses the operation when a message input falls. With the select low, recording is level-held: it continues while the input stays low and ends when the input rises or when the region's final sample has been written. An end-of-message write strobe then follows. With the select high, playback is edge-toggled: it ends at the region end, when the store reports an end marker, or on the next falling edge of the same input. While an operation runs, a row/sample address walks through the region on a sample-rate enable. Every operation finishes with a single-cycle power-down request.

Top module: `fmp_ctrl`

## Requirements
- R1: The configuration code is captured on the first clock after reset is released, and later changes to the code have no effect until the next reset.
- R2: Code c selects c+1 messages. The rows per message are: code 0 = 128; code 1 = 64,64; code 2 = 44,42,42; code 3 = 32 each; code 4 = 26,26,26,26,24; code 5 = 23 then 21 each; code 6 = 20 then 18 each; code 7 = 16 each. Regions are laid out in message order starting at row 0.
- R3: Message k is driven on msg_n[k-1], active low. With rp_sel=0, a falling input starts recording. The next clock goes to the recording state, and from then on rec_stb is high on each samp_tick cycle, beginning at (first row of the region, sample 0) and advancing sample-first. led_n is low throughout recording.
- R4: When the recording input rises, recording stops with no further rec_stb. eom_wr is then high for exactly one cycle, and pd_req is high for exactly one cycle on the cycle after that.
- R5: Recording that reaches the last sample of the region's last row stops there. Exactly rows×SAMP_PER_ROW rec_stb pulses are issued, followed by eom_wr and then pd_req.
- R6: With rp_sel=1, a falling input starts playback. play_stb is high on each samp_tick cycle across the whole region, and at the region end pd_req follows. There is no eom_wr, and led_n stays high.
- R7: During playback, a second falling edge on the same input stops play_stb and raises pd_req.
- R8: If eom_in is high on a play_stb cycle, playback ends, led_n is held low for LED_PULSE cycles, and then pd_req is raised.
- R9: Message inputs above the configured count start no operation.
- R10: If several inputs fall in the same cycle, the lowest-numbered message is the one served. All other inputs are ignored until pd_req.
- R11: At most one of rec_stb, play_stb, eom_wr and pd_req is high in any cycle, and no strobe is issued on a cycle where samp_tick is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_code | input | 3 | Message-count code, captured after reset |
| rp_sel | input | 1 | 0 = record, 1 = play |
| msg_n | input | MSG_N | Active-low message inputs; bit 0 is message 1 |
| samp_tick | input | 1 | Sample-rate enable |
| eom_in | input | 1 | End marker read back during playback |
| row_addr | output | 7 | Current row |
| samp_addr | output | SAMP_W | Current sample within the row |
| rec_stb | output | 1 | Write one sample |
| play_stb | output | 1 | Read one sample |
| eom_wr | output | 1 | Write end marker |
| led_n | output | 1 | Active-low indicator |
| pd_req | output | 1 | Single-cycle power-down request |

## Verification
The bench runs every configuration against the uneven table. It checks the first row, the last row and the exact strobe count of a region, so an off-by-one running sum or a misplaced leftover row would show up as a shifted start or a wrong pulse count. It drives simultaneous presses and presses that are still held after power-down; a design that re-arbitrates, or that takes a held input as a new edge, would start a second operation. It presses disabled inputs and changes the code after reset, which would start a region that should not exist. It stops playback by a second edge and by an end marker and counts the LED pulse; a toggle wrongly treated as a level, or a pulse of the wrong length, would give the wrong count.

// File: rtl/fmp_pkg.sv
package fmp_pkg;
  localparam int MSG_MAX = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REC, ST_PLAY, ST_EOMW, ST_LED, ST_PD
  } fmp_state_e;

  // rows allotted to message idx (0-based) under code cfg; 0 if unused
  function automatic logic [7:0] rows_of(input logic [2:0] cfg, input logic [2:0] idx);
    logic [7:0] r;
    if (idx > cfg) return 8'd0;
    case (cfg)
      3'd0: r = 8'd128;
      3'd1: r = 8'd64;
      3'd2: r = (idx == 3'd0) ? 8'd44 : 8'd42;
      3'd3: r = 8'd32;
      3'd4: r = (idx == 3'd4) ? 8'd24 : 8'd26;
      3'd5: r = (idx == 3'd0) ? 8'd23 : 8'd21;
      3'd6: r = (idx == 3'd0) ? 8'd20 : 8'd18;
      default: r = 8'd16;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] start_of(input logic [2:0] cfg, input logic [2:0] idx);
    logic [7:0] acc;
    acc = '0;
    for (int j = 0; j < MSG_MAX; j++)
      if (3'(j) < idx) acc = acc + rows_of(cfg, 3'(j));
    return acc;
  endfunction
endpackage

// File: rtl/fmp_region_rom.sv
module fmp_region_rom #(
  parameter int ROW_W = 7
) (
  input  logic [2:0]       cfg,
  input  logic [2:0]       idx,
  output logic [ROW_W-1:0] first_row,
  output logic [ROW_W-1:0] last_row
);
  logic [7:0] base, span, top;

  always_comb begin
    base = fmp_pkg::start_of(cfg, idx);
    span = fmp_pkg::rows_of(cfg, idx);
    top  = base + span - 8'd1;
  end

  assign first_row = base[ROW_W-1:0];
  assign last_row  = top[ROW_W-1:0];
endmodule

// File: rtl/fmp_pick.sv
module fmp_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fmp_seq.sv
module fmp_seq #(
  parameter int ROW_W        = 7,
  parameter int IW           = 3,
  parameter int SAMP_PER_ROW = 4,
  parameter int LED_PULSE    = 4,
  localparam int SAMP_W      = $clog2(SAMP_PER_ROW),
  localparam int LCW         = $clog2(LED_PULSE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_hit,
  input  logic [IW-1:0]     start_idx,
  input  logic              rp_sel,
  input  logic              sel_low,
  input  logic              sel_fall,
  input  logic [ROW_W-1:0]  first_row,
  input  logic [ROW_W-1:0]  last_row,
  input  logic              samp_tick,
  input  logic              eom_in,
  output logic              busy,
  output logic [IW-1:0]     cur_idx,
  output logic [ROW_W-1:0]  row_addr,
  output logic [SAMP_W-1:0] samp_addr,
  output logic              rec_stb,
  output logic              play_stb,
  output logic              eom_wr,
  output logic              led_n,
  output logic              pd_req
);
  import fmp_pkg::*;

  localparam logic [SAMP_W-1:0] SAMP_LAST = SAMP_W'(SAMP_PER_ROW - 1);

  fmp_state_e        state_q, state_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [SAMP_W-1:0] samp_q, samp_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [LCW-1:0]    lcnt_q, lcnt_d;
  logic              at_end;

  assign at_end = (row_q == last_row) && (samp_q == SAMP_LAST);

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    samp_d  = samp_q;
    idx_d   = idx_q;
    lcnt_d  = lcnt_q;
    case (state_q)
      ST_IDLE: if (start_hit) begin
        idx_d   = start_idx;
        row_d   = first_row;
        samp_d  = '0;
        state_d = rp_sel ? ST_PLAY : ST_REC;
      end
      ST_REC: begin
        if (!sel_low) state_d = ST_EOMW;
        else if (samp_tick) begin
          if (at_end) state_d = ST_EOMW;
          else if (samp_q == SAMP_LAST) begin
            samp_d = '0;
            row_d  = row_q + 1'b1;
          end else samp_d = samp_q + 1'b1;
        end
      end
      ST_PLAY: begin
        if (sel_fall) state_d = ST_PD;
        else if (samp_tick) begin
          if (eom_in) begin
            state_d = ST_LED;
            lcnt_d  = LCW'(LED_PULSE - 1);
          end else if (at_end) state_d = ST_PD;
          else if (samp_q == SAMP_LAST) begin
            samp_d = '0;
            row_d  = row_q + 1'b1;
          end else samp_d = samp_q + 1'b1;
        end
      end
      ST_EOMW: state_d = ST_PD;
      ST_LED: begin
        if (lcnt_q == '0) state_d = ST_PD;
        else lcnt_d = lcnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      samp_q  <= '0;
      idx_q   <= '0;
      lcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      samp_q  <= samp_d;
      idx_q   <= idx_d;
      lcnt_q  <= lcnt_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign cur_idx   = idx_q;
  assign row_addr  = row_q;
  assign samp_addr = samp_q;
  assign rec_stb   = (state_q == ST_REC) && samp_tick && sel_low;
  assign play_stb  = (state_q == ST_PLAY) && samp_tick && !sel_fall;
  assign eom_wr    = (state_q == ST_EOMW);
  assign pd_req    = (state_q == ST_PD);
  assign led_n     = !((state_q == ST_REC) || (state_q == ST_LED));
endmodule

// File: rtl/fmp_ctrl.sv
module fmp_ctrl #(
  parameter int MSG_N        = 8,
  parameter int ROW_W        = 7,
  parameter int SAMP_PER_ROW = 4,
  parameter int LED_PULSE    = 4,
  localparam int SAMP_W      = $clog2(SAMP_PER_ROW),
  localparam int IW          = $clog2(MSG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_code,
  input  logic              rp_sel,
  input  logic [MSG_N-1:0]  msg_n,
  input  logic              samp_tick,
  input  logic              eom_in,
  output logic [ROW_W-1:0]  row_addr,
  output logic [SAMP_W-1:0] samp_addr,
  output logic              rec_stb,
  output logic              play_stb,
  output logic              eom_wr,
  output logic              led_n,
  output logic              pd_req
);
  logic [2:0]       cfg_q;
  logic             cfg_ok_q;
  logic [MSG_N-1:0] msg_q, msg_en, fall;
  logic             pick_hit, busy;
  logic [IW-1:0]    pick_idx, cur_idx, rom_idx;
  logic [ROW_W-1:0] first_row, last_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cfg_ok_q <= 1'b0;
      msg_q    <= '1;
    end else begin
      if (!cfg_ok_q) cfg_q <= cfg_code;
      cfg_ok_q <= 1'b1;
      msg_q    <= msg_n;
    end
  end

  for (genvar g = 0; g < MSG_N; g++) begin : g_en
    assign msg_en[g] = cfg_ok_q && (g <= int'(cfg_q));
  end

  assign fall = msg_q & ~msg_n & msg_en;

  fmp_pick #(.N(MSG_N)) pick_i (
    .req(fall), .hit(pick_hit), .idx(pick_idx)
  );

  assign rom_idx = busy ? cur_idx : pick_idx;

  fmp_region_rom #(.ROW_W(ROW_W)) rom_i (
    .cfg(cfg_q), .idx(3'(rom_idx)), .first_row(first_row), .last_row(last_row)
  );

  fmp_seq #(
    .ROW_W(ROW_W), .IW(IW), .SAMP_PER_ROW(SAMP_PER_ROW), .LED_PULSE(LED_PULSE)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start_hit(pick_hit), .start_idx(pick_idx), .rp_sel(rp_sel),
    .sel_low(!msg_n[cur_idx]), .sel_fall(fall[cur_idx]),
    .first_row(first_row), .last_row(last_row),
    .samp_tick(samp_tick), .eom_in(eom_in),
    .busy(busy), .cur_idx(cur_idx),
    .row_addr(row_addr), .samp_addr(samp_addr),
    .rec_stb(rec_stb), .play_stb(play_stb), .eom_wr(eom_wr),
    .led_n(led_n), .pd_req(pd_req)
  );
endmodule

// File: rtl/fmp_ctrl_chk.sv
module fmp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       samp_tick,
  input logic       rec_stb,
  input logic       play_stb,
  input logic       eom_wr,
  input logic       led_n,
  input logic       pd_req,
  input logic [2:0] cfg_q,
  input logic       cfg_ok_q
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec_stb, play_stb, eom_wr, pd_req}));

  // R11
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_stb || play_stb) |-> samp_tick);

  // R4
  eom_then_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eom_wr |=> pd_req);

  // R4
  pd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> (!pd_req && !rec_stb && !play_stb));

  // R3
  rec_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_stb |-> !led_n);

  // R1
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok_q && $past(cfg_ok_q)) |-> $stable(cfg_q));
endmodule

bind fmp_ctrl fmp_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick),
  .rec_stb(rec_stb), .play_stb(play_stb), .eom_wr(eom_wr),
  .led_n(led_n), .pd_req(pd_req), .cfg_q(cfg_q), .cfg_ok_q(cfg_ok_q)
);

// File: tb/fmp_ctrl_tb_top.sv
module fmp_ctrl_tb_top;
  localparam int SPR = 2;
  localparam int LP  = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cfg_code;
  logic       rp_sel;
  logic [7:0] msg_n;
  logic       samp_tick;
  logic       eom_in;
  logic [6:0] row_addr;
  logic       samp_addr;
  logic       rec_stb, play_stb, eom_wr, led_n, pd_req;

  always #5 clk = ~clk;

  fmp_ctrl #(.SAMP_PER_ROW(SPR), .LED_PULSE(LP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code), .rp_sel(rp_sel),
    .msg_n(msg_n), .samp_tick(samp_tick), .eom_in(eom_in),
    .row_addr(row_addr), .samp_addr(samp_addr),
    .rec_stb(rec_stb), .play_stb(play_stb), .eom_wr(eom_wr),
    .led_n(led_n), .pd_req(pd_req)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  int n_rec, n_play, n_eom, n_pd, n_led, n_badtick, eom_cyc, pd_cyc;
  int first_row, first_samp, last_row, last_samp;
  bit seen, done = 1'b0;

  always @(negedge clk) begin
    if (rec_stb || play_stb) begin
      if (!seen) begin
        first_row = int'(row_addr); first_samp = int'(samp_addr); seen = 1'b1;
      end
      last_row = int'(row_addr); last_samp = int'(samp_addr);
      if (!samp_tick) n_badtick++;
    end
    if (rec_stb) n_rec++;
    if (play_stb) n_play++;
    if (eom_wr) begin n_eom++; eom_cyc = cyc; end
    if (pd_req) begin n_pd++; pd_cyc = cyc; end
    if (!led_n) n_led++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic clr();
    n_rec = 0; n_play = 0; n_eom = 0; n_pd = 0; n_led = 0; n_badtick = 0;
    eom_cyc = -10; pd_cyc = -20; seen = 1'b0;
    first_row = -1; first_samp = -1; last_row = -1; last_samp = -1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [2:0] c);
    #1;
    rst_n = 1'b0; cfg_code = c; msg_n = '1; rp_sel = 1'b0;
    samp_tick = 1'b1; eom_in = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
    clr();
  endtask

  task automatic wait_pd();
    for (int k = 0; k < 2000 && n_pd == 0; k++) step(1);
    step(2);
  endtask

  // {cfg[3], idx[3], play, start[8], rows[8]}
  localparam logic [22:0] VEC [8] = '{
    {3'd2, 3'd1, 1'b0, 8'd44,  8'd42},
    {3'd4, 3'd4, 1'b0, 8'd104, 8'd24},
    {3'd5, 3'd0, 1'b0, 8'd0,   8'd23},
    {3'd6, 3'd6, 1'b0, 8'd110, 8'd18},
    {3'd0, 3'd0, 1'b1, 8'd0,   8'd128},
    {3'd1, 3'd1, 1'b1, 8'd64,  8'd64},
    {3'd7, 3'd7, 1'b1, 8'd112, 8'd16},
    {3'd3, 3'd2, 1'b1, 8'd64,  8'd32}
  };

  initial begin
    rst_n = 1'b0; cfg_code = '0; rp_sel = 1'b0; msg_n = '1;
    samp_tick = 1'b1; eom_in = 1'b0;
    clr();

    // reset state
    do_reset(3'd0);
    chk("R1", "reset rec_stb", int'(rec_stb), 0);
    chk("R1", "reset pd_req", int'(pd_req), 0);
    chk("R1", "reset led_n", int'(led_n), 1);

    // R2 R3 R5 R6: region table walk
    foreach (VEC[v]) begin
      int st, rw, pl;
      st = int'(VEC[v][15:8]); rw = int'(VEC[v][7:0]); pl = int'(VEC[v][16]);
      do_reset(VEC[v][22:20]);
      rp_sel = VEC[v][16];
      msg_n[VEC[v][19:17]] = 1'b0;
      if (pl != 0) begin step(2); msg_n = '1; end
      wait_pd();
      msg_n = '1;
      step(2);
      chk(pl != 0 ? "R6" : "R5", "strobes", pl != 0 ? n_play : n_rec, rw * SPR);
      chk("R2", "first row", first_row, st);
      chk("R3", "first sample", first_samp, 0);
      chk("R2", "last row", last_row, st + rw - 1);
      chk(pl != 0 ? "R6" : "R5", "eom writes", n_eom, pl != 0 ? 0 : 1);
      chk("R6", "pd pulses", n_pd, 1);
      if (pl != 0) chk("R6", "led low cycles in play", n_led, 0);
      else chk("R3", "led low covers recording", int'(n_led >= n_rec), 1);
    end

    // R4: early release, then eom_wr then pd_req
    do_reset(3'd3);
    msg_n[0] = 1'b0;
    step(5);
    msg_n[0] = 1'b1;
    wait_pd();
    chk("R4", "rec strobes before release", n_rec, 4);
    chk("R4", "eom writes", n_eom, 1);
    chk("R4", "pd one cycle after eom", pd_cyc - eom_cyc, 1);

    // R11: tick gating with alternating samp_tick
    do_reset(3'd7);
    msg_n[0] = 1'b0;
    for (int k = 0; k < 200 && n_pd == 0; k++) begin
      samp_tick = ~samp_tick;
      step(1);
    end
    samp_tick = 1'b1;
    step(2);
    msg_n = '1;
    chk("R11", "strobes without tick", n_badtick, 0);
    chk("R11", "strobes with gated tick", n_rec, 16 * SPR);
    chk("R11", "last row with gated tick", last_row, 15);

    // R7: second edge stops playback
    do_reset(3'd0);
    rp_sel = 1'b1;
    msg_n[0] = 1'b0; step(2); msg_n[0] = 1'b1;
    step(10);
    msg_n[0] = 1'b0;
    step(3);
    msg_n[0] = 1'b1;
    chk("R7", "pd after second edge", n_pd, 1);
    chk("R7", "play stopped early", int'(n_play > 0 && n_play < 20), 1);
    clr(); step(10);
    chk("R7", "no play after stop", n_play, 0);

    // R8: end marker gives LED pulse then pd
    do_reset(3'd0);
    rp_sel = 1'b1;
    msg_n[0] = 1'b0; step(2); msg_n[0] = 1'b1;
    step(6);
    eom_in = 1'b1; step(1); eom_in = 1'b0;
    wait_pd();
    chk("R8", "led low cycles", n_led, LP);
    chk("R8", "pd pulses", n_pd, 1);
    chk("R8", "no eom write in play", n_eom, 0);

    // R9: message 6 with 3 messages configured
    do_reset(3'd2);
    msg_n[5] = 1'b0;
    step(20);
    msg_n = '1;
    chk("R9", "disabled input strobes", n_rec + n_play, 0);
    chk("R9", "disabled input led low", n_led, 0);
    chk("R9", "disabled input pd", n_pd, 0);

    // R10: simultaneous presses of messages 4 and 6
    do_reset(3'd7);
    msg_n[3] = 1'b0; msg_n[5] = 1'b0;
    step(6);
    msg_n[3] = 1'b1;
    wait_pd();
    chk("R10", "winner first row", first_row, 48);
    clr(); step(20);
    chk("R10", "held loser ignored after pd", n_rec + n_pd, 0);
    msg_n = '1;

    // R1: code change after reset ignored (1 message stays)
    do_reset(3'd0);
    cfg_code = 3'd7;
    step(2);
    msg_n[1] = 1'b0;
    step(10);
    msg_n = '1;
    chk("R1", "message 2 ignored after code change", n_rec + n_pd, 0);
    msg_n[0] = 1'b0;
    wait_pd();
    msg_n = '1;
    chk("R1", "message 1 keeps full region", n_rec, 128 * SPR);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule